// File: doc/BRIEF.md
# Limb-Parallel Prefix Carry Adder

The block adds two wide unsigned integers that are split into 32-bit limbs, with limb 0 the least significant. Each limb pair is summed on its own. Each limb then gets a two-bit carry class: kill, generate or propagate. A Hillis-Steele prefix scan over these classes works out which limbs receive a carry. In the final step, the resolved carry is added into the next limb up, and the carry out of the top limb becomes the carry output.

In the default build every step is registered: one register for the limb sums and one for each prefix level. The adder accepts a new operand pair on every cycle. A valid strobe moves through the pipeline alongside the data. With the default of 16 limbs (512 bits), a result appears five cycles after its operands. If the pipeline parameter is cleared, the whole path is combinational.

Top module: `pfx_limb_adder`

## Requirements
- R1: `{carry_o, sum_o}` equals the full `a_i + b_i` for the operands taken with `valid_i`: `sum_o` is the sum modulo 2^(32·NLIMBS) and `carry_o` is its next bit.
- R2: With the pipeline enabled, a result appears on `valid_o` exactly $clog2(NLIMBS)+1 cycles after its `valid_i` cycle, and `valid_o` pulses once per accepted operand pair.
- R3: While `rst_ni` is low and on the first cycles after it is released, `valid_o` stays low, even if `valid_i` is high during reset.
- R4: A limb whose raw sum is 0xFFFFFFFF passes the carry from the limb below it unchanged. Example: all-ones plus 1 gives a zero sum with `carry_o` = 1.
- R5: A chain of propagating limbs that has no generating limb below it delivers carry 0. Example: all-ones plus zero gives all-ones with `carry_o` = 0.
- R6: A limb whose raw sum does not wrap and is not all-ones (kill) stops a carry, so limbs above it see no carry from lower limbs. Example: limb pattern alternating 0xFFFFFFFF (limb 0) and 0 plus 1 changes only limbs 0 and 1.
- R7: Operand pairs on consecutive cycles are independent. Each result depends only on its own operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand pair present |
| a_i | input | 32·NLIMBS | First operand, limb 0 in bits 31:0 |
| b_i | input | 32·NLIMBS | Second operand |
| valid_o | output | 1 | Result present |
| sum_o | output | 32·NLIMBS | Sum modulo 2^(32·NLIMBS) |
| carry_o | output | 1 | Carry out of the top limb |

## Verification
The hardest case is a carry that starts in limb 0 and must cross every limb. A scan that drops a stride level, or reads the wrong neighbour, leaves some upper limbs without the increment. The inverse case is an all-propagate chain with no generating limb at its base. A design that treats a leftover propagate class as a carry adds one to every limb. Alternating propagate and zero limbs check that a kill limb really stops the carry; a wrong merge operator lets the carry leak past it. Random operands with many all-ones limbs, fed back-to-back, expose stage mixing and latency errors.

// File: rtl/pfx_add_pkg.sv
package pfx_add_pkg;
  localparam int unsigned LIMB_W = 32;

  // two-bit signed carry class: -1 propagate, 1 generate, 0 kill
  typedef logic [1:0] cflag_t;
  localparam cflag_t FLG_KILL = 2'b00;
  localparam cflag_t FLG_GEN  = 2'b01;
  localparam cflag_t FLG_PROP = 2'b11;

  // merge upper class with lower: signed max, then mask by upper
  function automatic cflag_t flag_merge(cflag_t upper, cflag_t lower);
    cflag_t big;
    big = ($signed(upper) > $signed(lower)) ? upper : lower;
    return big & upper;
  endfunction
endpackage

// File: rtl/limb_sum_stage.sv
module limb_sum_stage
  import pfx_add_pkg::*;
#(
  parameter int unsigned NLIMBS = 16,
  parameter int unsigned LW     = LIMB_W,
  parameter bit          REG    = 1'b1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [NLIMBS-1:0][LW-1:0]    a_i,
  input  logic [NLIMBS-1:0][LW-1:0]    b_i,
  output logic                         valid_o,
  output logic [NLIMBS-1:0][LW-1:0]    sum_o,
  output cflag_t [NLIMBS-1:0]          flag_o
);
  logic [NLIMBS-1:0][LW-1:0] sum_d;
  cflag_t [NLIMBS-1:0]       flag_d;

  for (genvar i = 0; i < NLIMBS; i++) begin : g_limb
    logic [LW:0] wide;
    assign wide     = {1'b0, a_i[i]} + {1'b0, b_i[i]};
    assign sum_d[i] = wide[LW-1:0];
    assign flag_d[i] = wide[LW]       ? FLG_GEN  :
                       (&wide[LW-1:0]) ? FLG_PROP : FLG_KILL;

    // generate class matches a wrapped limb sum
    p_gen_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_d[i] == FLG_GEN) == (sum_d[i] < a_i[i]));
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        sum_o   <= '0;
        flag_o  <= '0;
      end else begin
        valid_o <= valid_i;
        sum_o   <= sum_d;
        flag_o  <= flag_d;
      end
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign sum_o   = sum_d;
    assign flag_o  = flag_d;
  end
endmodule

// File: rtl/prefix_level.sv
module prefix_level
  import pfx_add_pkg::*;
#(
  parameter int unsigned NLIMBS = 16,
  parameter int unsigned LW     = LIMB_W,
  parameter int unsigned STRIDE = 1,
  parameter bit          REG    = 1'b1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [NLIMBS-1:0][LW-1:0]    sum_i,
  input  cflag_t [NLIMBS-1:0]          flag_i,
  output logic                         valid_o,
  output logic [NLIMBS-1:0][LW-1:0]    sum_o,
  output cflag_t [NLIMBS-1:0]          flag_o
);
  cflag_t [NLIMBS-1:0] flag_d;

  for (genvar i = 0; i < NLIMBS; i++) begin : g_pos
    if (i >= STRIDE) begin : g_merge
      assign flag_d[i] = flag_merge(flag_i[i], flag_i[i-STRIDE]);

      p_prop_take_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_i[i] == FLG_PROP) |-> (flag_d[i] == flag_i[i-STRIDE]));
      p_kill_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_i[i] == FLG_KILL) |-> (flag_d[i] == FLG_KILL));
      p_gen_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_i[i] == FLG_GEN) |-> (flag_d[i] == FLG_GEN));
    end else begin : g_ident
      // lower neighbour is the all-ones identity
      assign flag_d[i] = flag_i[i];
    end
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        sum_o   <= '0;
        flag_o  <= '0;
      end else begin
        valid_o <= valid_i;
        sum_o   <= sum_i;
        flag_o  <= flag_d;
      end
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign sum_o   = sum_i;
    assign flag_o  = flag_d;
  end
endmodule

// File: rtl/carry_apply.sv
module carry_apply
  import pfx_add_pkg::*;
#(
  parameter int unsigned NLIMBS = 16,
  parameter int unsigned LW     = LIMB_W
) (
  input  logic [NLIMBS-1:0][LW-1:0]    sum_i,
  input  cflag_t [NLIMBS-1:0]          flag_i,
  output logic [NLIMBS-1:0][LW-1:0]    sum_o,
  output logic                         carry_o
);
  // a resolved class left at propagate means no carry
  for (genvar i = 0; i < NLIMBS; i++) begin : g_out
    if (i == 0) begin : g_base
      assign sum_o[i] = sum_i[i];
    end else begin : g_up
      assign sum_o[i] = sum_i[i] + LW'(flag_i[i-1] == FLG_GEN);
    end
  end

  assign carry_o = (flag_i[NLIMBS-1] == FLG_GEN);
endmodule

// File: rtl/pfx_limb_adder.sv
module pfx_limb_adder
  import pfx_add_pkg::*;
#(
  parameter int unsigned NLIMBS = 16,
  parameter bit          PIPE   = 1'b1,
  localparam int unsigned LW     = LIMB_W,
  localparam int unsigned WIDTH  = NLIMBS * LW,
  localparam int unsigned LEVELS = (NLIMBS > 1) ? $clog2(NLIMBS) : 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  logic                      st_valid [LEVELS+1];
  logic [NLIMBS-1:0][LW-1:0] st_sum   [LEVELS+1];
  cflag_t [NLIMBS-1:0]       st_flag  [LEVELS+1];
  logic [NLIMBS-1:0][LW-1:0] final_sum;

  limb_sum_stage #(.NLIMBS(NLIMBS), .LW(LW), .REG(PIPE)) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (st_valid[0]),
    .sum_o   (st_sum[0]),
    .flag_o  (st_flag[0])
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    prefix_level #(
      .NLIMBS (NLIMBS),
      .LW     (LW),
      .STRIDE (1 << l),
      .REG    (PIPE)
    ) u_lvl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (st_valid[l]),
      .sum_i   (st_sum[l]),
      .flag_i  (st_flag[l]),
      .valid_o (st_valid[l+1]),
      .sum_o   (st_sum[l+1]),
      .flag_o  (st_flag[l+1])
    );
  end

  carry_apply #(.NLIMBS(NLIMBS), .LW(LW)) u_apply (
    .sum_i   (st_sum[LEVELS]),
    .flag_i  (st_flag[LEVELS]),
    .sum_o   (final_sum),
    .carry_o (carry_o)
  );

  assign sum_o   = final_sum;
  assign valid_o = st_valid[LEVELS];
endmodule

// File: tb/pfx_limb_adder_tb.sv
module pfx_limb_adder_tb;
  localparam int unsigned NL    = 16;
  localparam int unsigned W     = NL * 32;
  localparam int unsigned LAT   = $clog2(NL) + 1;
  localparam int unsigned NDIR  = 6;
  localparam int unsigned QD    = 256;

  localparam logic [W-1:0] TA [NDIR] = '{
    {W{1'b1}},
    {W{1'b0}},
    {W{1'b1}},
    {8{32'h0000_0000, 32'hFFFF_FFFF}},
    {16{32'h8000_0000}},
    {32'h7FFF_FFFF, {15{32'hFFFF_FFFF}}}
  };
  localparam logic [W-1:0] TB [NDIR] = '{
    W'(1),
    {W{1'b0}},
    {W{1'b0}},
    W'(1),
    {16{32'h8000_0000}},
    W'(1)
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic vout, cy;
  logic [W-1:0] sum;

  always #2.5 clk = ~clk;

  pfx_limb_adder #(.NLIMBS(NL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .a_i(a), .b_i(b),
    .valid_o(vout), .sum_o(sum), .carry_o(cy)
  );

  int checks = 0, errors = 0, cyc = 0;
  int wp = 0, rp = 0;
  logic [W:0]  q_exp [QD];
  int          q_cyc [QD];
  string       q_req [QD];

  function automatic string dir_req(int i);
    case (i)
      0: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic check_out();
    if (vout) begin
      checks++;
      if (rp == wp) begin
        errors++;
        $display("FAIL R2 unexpected valid_o: actual 1 expected 0");
      end else begin
        if ({cy, sum} !== q_exp[rp % QD]) begin
          errors++;
          $display("FAIL %s result: actual %h expected %h", q_req[rp % QD], {cy, sum}, q_exp[rp % QD]);
        end
        checks++;
        if (cyc - q_cyc[rp % QD] != LAT) begin
          errors++;
          $display("FAIL R2 latency: actual %0d expected %0d", cyc - q_cyc[rp % QD], LAT);
        end
        rp++;
      end
    end
  endtask

  // sample outputs, then drive next inputs, at the falling edge
  task automatic step(input logic v, input logic [W-1:0] na, input logic [W-1:0] nb, input string req);
    @(negedge clk);
    cyc++;
    check_out();
    vin = v; a = na; b = nb;
    if (v) begin
      q_exp[wp % QD] = {1'b0, na} + {1'b0, nb};
      q_cyc[wp % QD] = cyc;
      q_req[wp % QD] = req;
      wp++;
    end
  endtask

  function automatic logic [W-1:0] rnd_op();
    logic [W-1:0] r;
    for (int k = 0; k < NL; k++)
      r[k*32 +: 32] = ($urandom_range(3) == 0) ? 32'hFFFF_FFFF : $urandom;
    return r;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R3: valid_o low in reset, even with valid_i high
    vin = 1'b1; a = {W{1'b1}}; b = W'(1);
    repeat (3) @(negedge clk);
    checks++;
    if (vout !== 1'b0) begin
      errors++; $display("FAIL R3 valid_o in reset: actual %b expected 0", vout);
    end
    vin = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (vout !== 1'b0) begin
        errors++; $display("FAIL R3 valid_o after reset: actual %b expected 0", vout);
      end
    end

    // directed table, back to back
    for (int i = 0; i < NDIR; i++) step(1'b1, TA[i], TB[i], dir_req(i));
    for (int i = 0; i < LAT + 2; i++) step(1'b0, rnd_op(), rnd_op(), "R2");

    // R7: back-to-back random operands with propagate-heavy limbs
    for (int i = 0; i < 200; i++) step(1'b1, rnd_op(), rnd_op(), "R7");
    // gaps: idle cycles carry garbage that must not emerge (R2)
    for (int i = 0; i < 60; i++) step(($urandom_range(1) == 1), rnd_op(), rnd_op(), "R1");
    for (int i = 0; i < LAT + 3; i++) step(1'b0, rnd_op(), rnd_op(), "R2");

    checks++;
    if (rp != wp) begin
      errors++; $display("FAIL R2 results delivered: actual %0d expected %0d", rp, wp);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule